// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns two-channel PCM audio into the self-clocking serial stream used on consumer and professional digital audio links. Seen from the sample side it is a two-slot TDM transmitter. At the start of every subframe it takes one word per output lane, alternating left and right. It builds the subframe around that word: a sync preamble, 24 bits of auxiliary and audio data, then validity, user, channel-status and parity bits. The subframe goes out as 64 biphase-mark half-bit cells, so the receiver recovers clock and framing from the line itself.

A one-cycle cell strobe paces the stream, with one strobe per half-bit cell. The block does not divide or generate that rate. Channel-status and user data come from two 384-bit vectors. A block holds 192 frames, each a left and a right subframe, and each subframe uses one bit of each vector. Several lanes can run side by side. They share all timing and all side information, and each lane carries its own audio word, which may sit on any nibble boundary of a 32-bit input.

Top module: `spdif_tx`

## Requirements
- R1: After reset every lane output is low and `load_o` is low. Lane outputs change only on cycles that follow an asserted `cell_en_i`.
- R2: `load_o` is high on the strobe that starts each subframe, which is every 64th strobe, with the first strobe after reset counted as one. `chan_o` then gives the subframe's channel: 0 for left and 1 for right. Channels alternate, and the first subframe is left.
- R3: In slots 4 to 31 the line level inverts at the start of each slot. It inverts again at mid-slot only when that slot's bit is 1.
- R4: The first 8 cells carry a preamble, sent MSB first as levels above a low starting level: 11101000 on the left subframe of frame 0 of each 192-frame block, 11100010 on all other left subframes, and 11100100 on right subframes. The pattern is inverted if the level before the subframe is high.
- R5: Slots 4 to 27 carry bits 0 to 23 of the lane word shifted right by 4×`nib_off_i` bits, zero-filled, LSB first. Lane n uses `sample_i[32n+31:32n]`.
- R6: Slot 28 carries `valid_l_i` in left subframes and `valid_r_i` in right subframes.
- R7: Slot 29 carries `udata_i[k]` and slot 30 carries `cstat_i[k]`, where k = 2×frame + channel (0 to 383).
- R8: Slot 31 makes slots 4 to 31 even parity, so each subframe ends at the level it started at. That level is low.
- R9: All lanes share cell timing, preambles and validity, user and channel-status bits. Only the audio field and the parity differ between lanes.
- R10: All inputs are sampled only on the `load_o` cycle. Changes at any other time do not affect the subframe in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cell_en_i | input | 1 | One-cycle strobe per half-bit cell |
| sample_i | input | 32*LANES | One audio word per lane |
| nib_off_i | input | 3 | Nibble offset of the audio field inside the word |
| valid_l_i | input | 1 | Validity bit for left subframes |
| valid_r_i | input | 1 | Validity bit for right subframes |
| cstat_i | input | 384 | Channel-status bits, one per subframe of a block |
| udata_i | input | 384 | User-data bits, one per subframe of a block |
| load_o | output | 1 | Inputs taken this cycle for the next subframe |
| chan_o | output | 1 | Channel of the subframe being loaded |
| sdo_o | output | LANES | Biphase-mark line per lane |

## Verification
Two situations are hard to reach from the ports. The first is the wrap from frame 191 back to frame 0, where the preamble must switch back to the block-start pattern and the status index must return from 383 to 0. To reach it, the stimulus strobes a cell on every cycle for more than two full blocks, after an opening stretch of irregular strobe gaps. The second is the rule that only load-time inputs count. To test it, the bench changes every sample, offset and validity input on every cycle. It changes the status and user vectors once, in the middle of the run. The reference model captures inputs only at its own subframe starts.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 24;
  localparam int PAY_W     = FIELD_W + 4;
  localparam int CELLS     = 64;
  localparam int PRE_CELLS = 8;
  localparam int NIB_W     = $clog2(WORD_W / 4);
  localparam int CELL_W    = $clog2(CELLS);
  // preamble cell levels, MSB first, relative to a low starting level
  localparam logic [PRE_CELLS-1:0] PRE_BLK   = 8'b11101000;
  localparam logic [PRE_CELLS-1:0] PRE_LEFT  = 8'b11100010;
  localparam logic [PRE_CELLS-1:0] PRE_RIGHT = 8'b11100100;
endpackage

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq
  import spdif_tx_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cell_en_i,
  output logic                 load_o,
  output logic                 chan_o,
  output logic [FW:0]          sf_idx_o,
  output logic [PRE_CELLS-1:0] pat_o,
  output logic [CELL_W-1:0]    ncell_o
);
  logic [CELL_W-1:0] cnt_q;
  logic              side_q;
  logic [FW-1:0]     frame_q;

  assign load_o   = cell_en_i && (cnt_q == CELL_W'(CELLS - 1));
  assign ncell_o  = cnt_q + 1'b1;
  assign chan_o   = side_q;
  assign sf_idx_o = {frame_q, side_q};
  assign pat_o    = side_q ? PRE_RIGHT : (frame_q == '0) ? PRE_BLK : PRE_LEFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CELL_W'(CELLS - 1);
      side_q  <= 1'b0;
      frame_q <= '0;
    end else if (cell_en_i) begin
      cnt_q <= ncell_o;
      if (load_o) begin
        side_q <= ~side_q;
        if (side_q) frame_q <= (frame_q == FW'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spdif_tx_fmt.sv
module spdif_tx_fmt
  import spdif_tx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              v_i,
  input  logic              u_i,
  input  logic              c_i,
  output logic [PAY_W-1:0]  pay_o
);
  logic [WORD_W-1:0]  aligned;
  logic [FIELD_W-1:0] field;

  assign aligned = word_i >> {nib_i, 2'b00};
  assign field   = aligned[FIELD_W-1:0];
  assign pay_o   = {^{c_i, u_i, v_i, field}, c_i, u_i, v_i, field};
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc
  import spdif_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cell_en_i,
  input  logic                 load_i,
  input  logic [CELL_W-1:0]    ncell_i,
  input  logic [PRE_CELLS-1:0] pat_i,
  input  logic [PAY_W-1:0]     pay_i,
  output logic                 line_o
);
  logic                 line_q, base_q, line_d;
  logic [PRE_CELLS-1:0] pat_q, pat_eff;
  logic [PAY_W-1:0]     pay_q;
  logic                 base_eff;
  logic [4:0]           pidx;

  assign pat_eff  = load_i ? pat_i : pat_q;
  assign base_eff = load_i ? line_q : base_q;
  assign pidx     = 5'(ncell_i[CELL_W-1:1]) - 5'd4;

  always_comb begin
    if (ncell_i < CELL_W'(PRE_CELLS))
      line_d = base_eff ^ pat_eff[3'd7 - ncell_i[2:0]];
    else if (!ncell_i[0])
      line_d = ~line_q;
    else
      line_d = line_q ^ pay_q[pidx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
      pat_q  <= '0;
      pay_q  <= '0;
    end else if (cell_en_i) begin
      line_q <= line_d;
      if (load_i) begin
        base_q <= line_q;
        pat_q  <= pat_i;
        pay_q  <= pay_i;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int FRAMES = 192,
  localparam int SF    = 2 * FRAMES,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cell_en_i,
  input  logic [LANES*WORD_W-1:0] sample_i,
  input  logic [NIB_W-1:0]        nib_off_i,
  input  logic                    valid_l_i,
  input  logic                    valid_r_i,
  input  logic [SF-1:0]           cstat_i,
  input  logic [SF-1:0]           udata_i,
  output logic                    load_o,
  output logic                    chan_o,
  output logic [LANES-1:0]        sdo_o
);
  logic [FW:0]          sf_idx;
  logic [PRE_CELLS-1:0] pat;
  logic [CELL_W-1:0]    ncell;
  logic                 v_bit, u_bit, c_bit;

  spdif_tx_seq #(.FRAMES(FRAMES)) u_seq (
    .clk_i, .rst_ni, .cell_en_i,
    .load_o, .chan_o, .sf_idx_o(sf_idx), .pat_o(pat), .ncell_o(ncell)
  );

  assign v_bit = chan_o ? valid_r_i : valid_l_i;
  assign u_bit = udata_i[sf_idx];
  assign c_bit = cstat_i[sf_idx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PAY_W-1:0] pay;
    spdif_tx_fmt u_fmt (
      .word_i(sample_i[l*WORD_W +: WORD_W]), .nib_i(nib_off_i),
      .v_i(v_bit), .u_i(u_bit), .c_i(c_bit), .pay_o(pay)
    );
    spdif_tx_bmc u_bmc (
      .clk_i, .rst_ni, .cell_en_i, .load_i(load_o), .ncell_i(ncell),
      .pat_i(pat), .pay_i(pay), .line_o(sdo_o[l])
    );
  end
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cell_en_i,
  input logic             load_i,
  input logic             chan_i,
  input logic [5:0]       ncell_i,
  input logic [LANES-1:0] sdo_i
);
  logic seen_q, last_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else if (load_i) begin
      seen_q <= 1'b1;
      last_q <= chan_i;
    end
  end

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_en_i |=> $stable(sdo_i));

  assert_alt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seen_q) |-> (chan_i != last_q));

  assert_first_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !seen_q) |-> !chan_i);

  assert_slot_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_en_i && !ncell_i[0] && ncell_i >= 6'd8) |=> (sdo_i == ~$past(sdo_i)));

  assert_pre_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdo_i == '1));

  assert_even_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (sdo_i == '0));
endmodule

bind spdif_tx spdif_tx_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cell_en_i(cell_en_i), .load_i(load_o),
  .chan_i(chan_o), .ncell_i(ncell), .sdo_i(sdo_o)
);

// File: tb/spdif_tx_tb.sv
module spdif_tx_tb;
  localparam int LANES = 2;
  localparam int TOTAL = 56000;
  localparam int WDOG  = 200000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 cell_en = 1'b0;
  logic [LANES*32-1:0]  sample = '0;
  logic [2:0]           nib = '0;
  logic                 vl = 1'b0, vr = 1'b0;
  logic [383:0]         cs = '0, ud = '0;
  logic                 load, chan;
  logic [LANES-1:0]     sdo;

  spdif_tx #(.LANES(LANES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cell_en_i(cell_en), .sample_i(sample),
    .nib_off_i(nib), .valid_l_i(vl), .valid_r_i(vr), .cstat_i(cs),
    .udata_i(ud), .load_o(load), .chan_o(chan), .sdo_o(sdo)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int   m_cell = 63, m_side = 0, m_frame = 0;
  bit   m_started = 1'b0;
  logic seq [LANES][64];
  logic exp_line [LANES];

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cell %0d frame %0d)", tag, got, exp, m_cell, m_frame);
    end
  endtask

  task automatic build(input int l);
    logic [31:0] w;
    logic [23:0] f;
    logic [7:0]  pat;
    logic        bits [28];
    logic        lvl, par;
    int          k;
    w   = sample[l*32 +: 32] >> (4 * nib);
    f   = w[23:0];
    k   = 2 * m_frame + m_side;
    pat = (m_side == 1) ? 8'b11100100 : (m_frame == 0) ? 8'b11101000 : 8'b11100010;
    par = 1'b0;
    for (int i = 0; i < 24; i++) bits[i] = f[i];
    bits[24] = (m_side == 1) ? vr : vl;
    bits[25] = ud[k];
    bits[26] = cs[k];
    for (int i = 0; i < 27; i++) par ^= bits[i];
    bits[27] = par;
    lvl = exp_line[l];
    for (int c = 0; c < 8; c++) seq[l][c] = lvl ^ pat[7 - c];
    lvl = seq[l][7];
    for (int s = 4; s < 32; s++) begin
      lvl = ~lvl;
      seq[l][2*s] = lvl;
      if (bits[s-4]) lvl = ~lvl;
      seq[l][2*s+1] = lvl;
    end
  endtask

  task automatic model_step();
    if (!cell_en) return;
    if (m_cell == 63) begin
      for (int l = 0; l < LANES; l++) build(l);
      m_cell = 0;
      m_started = 1'b1;
      if (m_side == 1) m_frame = (m_frame == 191) ? 0 : m_frame + 1;
      m_side = 1 - m_side;
    end else begin
      m_cell++;
    end
    for (int l = 0; l < LANES; l++) exp_line[l] = seq[l][m_cell];
  endtask

  task automatic drive(input int i);
    cell_en = (i < 3000) ? ($urandom % 3 == 0) : 1'b1;
    for (int l = 0; l < LANES; l++) sample[l*32 +: 32] = $urandom;
    nib = 3'($urandom % 8);
    vl  = 1'($urandom);
    vr  = 1'($urandom);
    if (i == 30000)
      for (int j = 0; j < 12; j++) begin
        cs[j*32 +: 32] = $urandom;
        ud[j*32 +: 32] = $urandom;
      end
  endtask

  task automatic compare();
    bit    exp_load;
    int    slot;
    string tag;
    exp_load = cell_en && (m_cell == 63);
    check(load == exp_load, "R2 load", int'(load), int'(exp_load));
    if (exp_load) check(chan == 1'(m_side), "R2 chan", int'(chan), m_side);
    slot = m_cell / 2;
    for (int l = 0; l < LANES; l++) begin
      if (!m_started)       tag = "R1 idle";
      else if (slot < 4)    tag = "R4 preamble";
      else if (slot < 28)   tag = "R3 R5 R10 audio";
      else if (slot == 28)  tag = "R6 validity";
      else if (slot < 31)   tag = "R7 user/status";
      else                  tag = "R8 parity";
      if (l > 0) tag = {tag, " R9 lane"};
      check(sdo[l] == exp_line[l], tag, int'(sdo[l]), int'(exp_line[l]));
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) exp_line[l] = 1'b0;
    for (int j = 0; j < 12; j++) begin
      cs[j*32 +: 32] = $urandom;
      ud[j*32 +: 32] = $urandom;
    end
    repeat (3) @(negedge clk);
    check(sdo == '0, "R1 reset lines", int'(sdo), 0);
    check(load == 1'b0, "R1 reset load", int'(load), 0);
    rst_n = 1'b1;
    for (int i = 0; i < TOTAL; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      drive(i);
      #1;
      compare();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule